// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called the A side and the B side. Each transfer direction has its own capture register, and each register has its own capture clock. A word from A can therefore be held for later delivery to B, and a word from B can be held for A, each at its own time. A select input for each direction chooses what the output carries: the live word from the opposite side or the held word. Two further controls set the drive: an isolate input and a direction input. Together they decide which side, if either, the block drives.

Tri-state pads are modelled as three separate signals for each side: an input bus, an output bus and an output-enable. The output buses always carry the selected data. The enables say whether that data is actually placed on the pads. The block is built from identical independent lanes, by default two lanes of eight bits, and each lane has its own full control set. If the controls of every lane are tied together, the block works as one wide transceiver.

Top module: `txr_bus_top`

## Requirements
- R1: A rising edge of a lane's `clk_ab` (or `clk_ba`) while `rst` is 1 clears that lane's A-to-B (or B-to-A) register to 0. Registers of other lanes and of the other direction are not touched.
- R2: A rising edge of lane h's `clk_ab` with `rst` at 0 stores `a_in[h*8+:8]`. While `sel_ab[h]` is 1, `b_out[h*8+:8]` shows the stored word and holds it until the next `clk_ab[h]` edge, whatever `a_in` does.
- R3: A rising edge of lane h's `clk_ba` with `rst` at 0 stores `b_in[h*8+:8]`. While `sel_ba[h]` is 1, `a_out[h*8+:8]` shows the stored word and holds it until the next `clk_ba[h]` edge.
- R4: While `sel_ab[h]` is 0, `b_out` lane h equals `a_in` lane h, with no clock edge needed. While `sel_ba[h]` is 0, `a_out` lane h equals `b_in` lane h. A change of a select input takes effect at the output at once.
- R5: With `iso[h]` at 0, `dir_atob[h]` = 1 gives `b_oe[h]`=1 and `a_oe[h]`=0. `dir_atob[h]` = 0 gives `a_oe[h]`=1 and `b_oe[h]`=0.
- R6: With `iso[h]` at 1, both `a_oe[h]` and `b_oe[h]` are 0.
- R7: `a_oe[h]` and `b_oe[h]` are never 1 at the same time.
- R8: Both registers capture on their clocks whatever `iso`, `dir_atob` and the selects hold. Both may capture in the same instant, and words captured while the lane is isolated appear on the output once it is enabled.
- R9: Each lane's controls affect only that lane's bits and enables. Giving all lanes the same controls makes the block act as one 16-bit transceiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high clear, sampled on each capture clock |
| clk_ab | input | NUM_HALVES | Per-lane capture clock of the A-to-B register |
| clk_ba | input | NUM_HALVES | Per-lane capture clock of the B-to-A register |
| iso | input | NUM_HALVES | Per-lane isolate: 1 disables both drivers |
| dir_atob | input | NUM_HALVES | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | NUM_HALVES | Per-lane B output source: 1 stored, 0 live |
| sel_ba | input | NUM_HALVES | Per-lane A output source: 1 stored, 0 live |
| a_in | input | LANE_W*NUM_HALVES | Data sensed on the A pads |
| b_in | input | LANE_W*NUM_HALVES | Data sensed on the B pads |
| a_out | output | LANE_W*NUM_HALVES | Data offered to the A pads |
| b_out | output | LANE_W*NUM_HALVES | Data offered to the B pads |
| a_oe | output | NUM_HALVES | Per-lane drive enable of the A pads |
| b_oe | output | NUM_HALVES | Per-lane drive enable of the B pads |

## Verification
Two events can fall in the same instant: a capture edge and a read of the stored word through the select path. Both capture clocks of one lane can also rise together while the other controls change the drive state. The bench sets a stored select, presents a new word and pulses the capture clock. It then checks that the output moves to the new word only after that edge, and that a later change on the input leaves the output alone. In a second case it pulses both directions at once while the lane is isolated, then enables the lane. There it expects each output to carry its own captured word and only the enable chosen by the direction input to be set.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } txr_dir_e;
endpackage

// File: rtl/txr_capture_reg.sv
module txr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/txr_out_sel.sv
module txr_out_sel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  input  logic             use_held,
  output logic [WIDTH-1:0] y
);
  always_comb y = use_held ? held : live;
endmodule

// File: rtl/txr_drive_ctl.sv
module txr_drive_ctl
  import txr_pkg::*;
(
  input  logic     iso,
  input  txr_dir_e dir,
  output logic     a_oe,
  output logic     b_oe
);
  always_comb begin
    a_oe = 1'b0;
    b_oe = 1'b0;
    if (!iso) begin
      if (dir == DIR_TO_B) b_oe = 1'b1;
      else                 a_oe = 1'b1;
    end
  end
endmodule

// File: rtl/txr_half.sv
module txr_half
  import txr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rst,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             iso,
  input  logic             dir_atob,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_oe,
  output logic             b_oe
);
  logic [WIDTH-1:0] held_ab;
  logic [WIDTH-1:0] held_ba;
  txr_dir_e         dir_e;

  always_comb dir_e = dir_atob ? DIR_TO_B : DIR_TO_A;

  txr_capture_reg #(.WIDTH(WIDTH)) i_reg_ab (
    .clk(clk_ab), .rst(rst), .d(a_in), .q(held_ab)
  );
  txr_capture_reg #(.WIDTH(WIDTH)) i_reg_ba (
    .clk(clk_ba), .rst(rst), .d(b_in), .q(held_ba)
  );
  txr_out_sel #(.WIDTH(WIDTH)) i_sel_b (
    .live(a_in), .held(held_ab), .use_held(sel_ab), .y(b_out)
  );
  txr_out_sel #(.WIDTH(WIDTH)) i_sel_a (
    .live(b_in), .held(held_ba), .use_held(sel_ba), .y(a_out)
  );
  txr_drive_ctl i_ctl (
    .iso(iso), .dir(dir_e), .a_oe(a_oe), .b_oe(b_oe)
  );
endmodule

// File: rtl/txr_bus_top.sv
module txr_bus_top #(
  parameter int LANE_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input  logic                           rst,
  input  logic [NUM_HALVES-1:0]          clk_ab,
  input  logic [NUM_HALVES-1:0]          clk_ba,
  input  logic [NUM_HALVES-1:0]          iso,
  input  logic [NUM_HALVES-1:0]          dir_atob,
  input  logic [NUM_HALVES-1:0]          sel_ab,
  input  logic [NUM_HALVES-1:0]          sel_ba,
  input  logic [LANE_W*NUM_HALVES-1:0]   a_in,
  input  logic [LANE_W*NUM_HALVES-1:0]   b_in,
  output logic [LANE_W*NUM_HALVES-1:0]   a_out,
  output logic [LANE_W*NUM_HALVES-1:0]   b_out,
  output logic [NUM_HALVES-1:0]          a_oe,
  output logic [NUM_HALVES-1:0]          b_oe
);
  localparam int BUS_W = LANE_W * NUM_HALVES;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    txr_half #(.WIDTH(LANE_W)) i_half (
      .rst     (rst),
      .clk_ab  (clk_ab[h]),
      .clk_ba  (clk_ba[h]),
      .iso     (iso[h]),
      .dir_atob(dir_atob[h]),
      .sel_ab  (sel_ab[h]),
      .sel_ba  (sel_ba[h]),
      .a_in    (a_in[h*LANE_W +: LANE_W]),
      .b_in    (b_in[h*LANE_W +: LANE_W]),
      .a_out   (a_out[h*LANE_W +: LANE_W]),
      .b_out   (b_out[h*LANE_W +: LANE_W]),
      .a_oe    (a_oe[h]),
      .b_oe    (b_oe[h])
    );
  end

  if (BUS_W < 1) begin : g_bad_width
    initial $error("txr_bus_top: empty bus");
  end
endmodule

// File: rtl/txr_bus_chk.sv
module txr_bus_chk #(
  parameter int LANE_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input logic                         rst,
  input logic [NUM_HALVES-1:0]        clk_ab,
  input logic [NUM_HALVES-1:0]        clk_ba,
  input logic [NUM_HALVES-1:0]        iso,
  input logic [NUM_HALVES-1:0]        dir_atob,
  input logic [NUM_HALVES-1:0]        sel_ab,
  input logic [NUM_HALVES-1:0]        sel_ba,
  input logic [LANE_W*NUM_HALVES-1:0] a_in,
  input logic [LANE_W*NUM_HALVES-1:0] b_in,
  input logic [LANE_W*NUM_HALVES-1:0] a_out,
  input logic [LANE_W*NUM_HALVES-1:0] b_out,
  input logic [NUM_HALVES-1:0]        a_oe,
  input logic [NUM_HALVES-1:0]        b_oe
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    logic primed_ab = 1'b0;
    logic primed_ba = 1'b0;

    always_ff @(posedge clk_ab[h]) primed_ab <= primed_ab | rst;
    always_ff @(posedge clk_ba[h]) primed_ba <= primed_ba | rst;

    assert_clear_ab_R1: assert property (@(posedge clk_ab[h]) disable iff (rst)
      (primed_ab && sel_ab[h] && $past(rst)) |-> (b_out[h*LANE_W +: LANE_W] == '0));
    assert_clear_ba_R1: assert property (@(posedge clk_ba[h]) disable iff (rst)
      (primed_ba && sel_ba[h] && $past(rst)) |-> (a_out[h*LANE_W +: LANE_W] == '0));

    assert_stored_ab_R2: assert property (@(posedge clk_ab[h]) disable iff (rst)
      (primed_ab && sel_ab[h] && !$past(rst))
        |-> (b_out[h*LANE_W +: LANE_W] == $past(a_in[h*LANE_W +: LANE_W])));
    assert_stored_ba_R3: assert property (@(posedge clk_ba[h]) disable iff (rst)
      (primed_ba && sel_ba[h] && !$past(rst))
        |-> (a_out[h*LANE_W +: LANE_W] == $past(b_in[h*LANE_W +: LANE_W])));

    assert_live_ab_R4: assert property (@(posedge clk_ab[h]) disable iff (rst)
      !sel_ab[h] |-> (b_out[h*LANE_W +: LANE_W] == a_in[h*LANE_W +: LANE_W]));
    assert_live_ba_R4: assert property (@(posedge clk_ba[h]) disable iff (rst)
      !sel_ba[h] |-> (a_out[h*LANE_W +: LANE_W] == b_in[h*LANE_W +: LANE_W]));

    assert_isolated_R6: assert property (@(posedge clk_ab[h]) disable iff (rst)
      iso[h] |-> (!a_oe[h] && !b_oe[h]));

    assert_one_driver_R7: assert property (@(posedge clk_ab[h]) disable iff (rst)
      !(a_oe[h] && b_oe[h]));
    assert_one_driver_ba_R7: assert property (@(posedge clk_ba[h]) disable iff (rst)
      $countones({a_oe[h], b_oe[h]}) <= 1);
  end
endmodule

bind txr_bus_top txr_bus_chk #(.LANE_W(LANE_W), .NUM_HALVES(NUM_HALVES)) i_chk (.*);

// File: tb/test_txr_bus_top.sv
`timescale 1ns/1ps
module test_txr_bus_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int NH = 2;
  localparam int BW = LW * NH;

  logic          rst;
  logic [NH-1:0] clk_ab, clk_ba, iso, dir_atob, sel_ab, sel_ba;
  logic [BW-1:0] a_in, b_in, a_out, b_out;
  logic [NH-1:0] a_oe, b_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  txr_bus_top #(.LANE_W(LW), .NUM_HALVES(NH)) i_txr_bus_top (
    .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba), .iso(iso),
    .dir_atob(dir_atob), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_oe(a_oe), .b_oe(b_oe)
  );

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [NH-1:0] m_ab, logic [NH-1:0] m_ba);
    #1;
    clk_ab = m_ab;
    clk_ba = m_ba;
    #(CLK_PERIOD/2);
    clk_ab = '0;
    clk_ba = '0;
    #(CLK_PERIOD/2);
  endtask

  task automatic t_reset();
    rst = 1; a_in = 16'hFFFF; b_in = 16'hFFFF; sel_ab = '1; sel_ba = '1;
    pulse('1, '1);
    rst = 0;
    #1;
    check("R1 reset b_out", b_out, '0);
    check("R1 reset a_out", a_out, '0);
  endtask

  task automatic t_live();
    sel_ab = '0; sel_ba = '0;
    foreach (a_in[i]) ;
    a_in = 16'h5AC3; b_in = 16'h0F1E; #1;
    check("R4 live b_out", b_out, 16'h5AC3);
    check("R4 live a_out", a_out, 16'h0F1E);
    a_in = 16'hFF00; b_in = 16'h00FF; #1;
    check("R4 live b_out 2", b_out, 16'hFF00);
    check("R4 live a_out 2", a_out, 16'h00FF);
    sel_ab = '1; sel_ba = '1; #1;
    check("R4 select to stored b", b_out, 16'h0000);
    check("R4 select to stored a", a_out, 16'h0000);
  endtask

  task automatic t_store();
    sel_ab = '1; sel_ba = '1;
    a_in = 16'hA53C; pulse('1, '0);
    a_in = 16'h1234; #1;
    check("R2 stored held", b_out, 16'hA53C);
    check("R3 a side untouched", a_out, 16'h0000);
    b_in = 16'h6699; pulse('0, '1);
    b_in = 16'h0000; #1;
    check("R3 stored held", a_out, 16'h6699);
    check("R2 b side untouched", b_out, 16'hA53C);
    pulse('1, '0); #1;
    check("R2 next capture", b_out, 16'h1234);
  endtask

  task automatic t_enables();
    for (int c = 0; c < 4; c++) begin
      iso = {NH{c[1]}}; dir_atob = {NH{c[0]}}; #1;
      check("R5/R6 b_oe", {14'd0, b_oe}, {14'd0, {NH{!c[1] && c[0]}}});
      check("R5/R6 a_oe", {14'd0, a_oe}, {14'd0, {NH{!c[1] && !c[0]}}});
      check("R7 exclusive", {14'd0, a_oe & b_oe}, '0);
    end
  endtask

  task automatic t_isolated_capture();
    iso = '1; sel_ab = '1; sel_ba = '1;
    a_in = 16'hC0DE; b_in = 16'hBEEF; pulse('1, '1);
    a_in = 16'h0; b_in = 16'h0;
    iso = '0; dir_atob = '1; #1;
    check("R8 b_out after isolate", b_out, 16'hC0DE);
    check("R8 a_out after isolate", a_out, 16'hBEEF);
    check("R8 b_oe", {14'd0, b_oe}, {14'd0, 2'b11});
    check("R8 a_oe", {14'd0, a_oe}, '0);
  endtask

  task automatic t_lanes();
    sel_ab = 2'b11;
    a_in = 16'h7788; pulse(2'b01, 2'b00); #1;
    check("R9 lane0 only capture", b_out, 16'hC088);
    sel_ab = 2'b01; #1;
    check("R9 per lane select", b_out, 16'h7788);
    iso = 2'b00; dir_atob = 2'b10; #1;
    check("R9 per lane b_oe", {14'd0, b_oe}, {14'd0, 2'b10});
    check("R9 per lane a_oe", {14'd0, a_oe}, {14'd0, 2'b01});
    sel_ab = 2'b11; rst = 1; pulse(2'b10, 2'b00); rst = 0; #1;
    check("R1 lane1 clear only", b_out, 16'h0088);
  endtask

  initial begin
    clk_ab = '0; clk_ba = '0; iso = '1; dir_atob = '0;
    sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0; rst = 1;
    #(CLK_PERIOD);
    t_reset();
    t_live();
    t_store();
    t_enables();
    t_isolated_capture();
    t_lanes();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule